// File: doc/BRIEF.md
# Gated-Divider Serial Receiver with Stable-Zone Checking

This block receives asynchronous serial bytes (one start bit, eight data bits sent least significant bit first, one stop bit). Its baud divider does not run while the line is idle: the count sits at zero until a falling edge of the synchronised line starts a frame. The divider stops again as soon as the stop bit has been sampled. The receive divisor is a plain input of its own, so the receive rate is set apart from any transmitter.

Each bit is split into a small number of divider ticks, two or three, instead of the usual sixteen. With two ticks per bit, the receiver samples at odd tick numbers. With three ticks per bit, the first third of each bit is a transition zone. The receiver takes a reference level at the end of that zone and samples at the second tick. If the line moves away from the reference while the bit should be stable, the frame is reported with a stability error. Results come out as one-cycle pulses, one set per frame.

Top module: `gated_uart_rx`

## Requirements
- R1: After reset, `rx_valid`, `frame_err` and `stab_err` are 0 and `rx_byte` is 0x00. While no frame is in progress, the divider count stays at 0.
- R2: While idle, a high-to-low change of the synchronised line starts a frame. The divisor and mode are captured at that point, so later changes have no effect on the frame in progress. A tick occurs every max(`divisor`,1) clocks.
- R3: With `tick3_mode`=0 (two ticks per bit), the start bit is sampled at tick 1, data bit i (i=0..7, LSB first) at tick 3+2i, and the stop bit at tick 19.
- R4: With `tick3_mode`=1 (three ticks per bit), bit k occupies ticks 3k to 3k+3. The reference level is taken at tick 3k+1, the sample at tick 3k+2, and the stop bit is sampled at tick 29.
- R5: If the start sample reads high, the receiver returns to idle and produces no output pulse for that edge.
- R6: If the stop sample reads low, `frame_err` pulses for one cycle and `rx_valid` stays 0.
- R7: If the stop sample reads high, `rx_valid` pulses for one cycle and `rx_byte` holds the eight data bits.
- R8: With `tick3_mode`=1, a line level that differs from the reference between tick 3k+1 and tick 3k+3 of any bit makes `stab_err` pulse in the same cycle as that frame's `rx_valid` or `frame_err`. Changes in the transition zone are not flagged, and `stab_err` never rises with `tick3_mode`=0.
- R9: After the stop sample the divider returns to 0 and the receiver goes idle. A frame that starts right at the end of the previous stop bit is received.
- R10: Each output pulse lasts one cycle, and `rx_valid` and `frame_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | DIV_W | Clocks per tick (0 treated as 1) |
| tick3_mode | input | 1 | 0: two ticks per bit, 1: three ticks per bit with stable-zone check |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_byte | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle pulse: frame with a good stop bit |
| stab_err | output | 1 | One-cycle pulse: line moved inside a stable zone |
| frame_err | output | 1 | One-cycle pulse: stop bit sampled low |

## Verification
A wrong phase or bit index moves every later sample point. That shows as a wrong `rx_byte` or a spurious `frame_err` at the end of the same frame, 20 or 30 ticks after the start edge. A divider that fails to clear or stop leaves the next frame misaligned, so the error appears on the following frame. A stuck busy state shows as a missing pulse within one frame time. A stability flag that is not cleared at the start edge shows as `stab_err` on the next clean frame.

// File: rtl/gurx_pkg.sv
package gurx_pkg;
  localparam int DATA_W   = 8;
  localparam int STOP_IDX = DATA_W + 1;
  localparam int BIDX_W   = $clog2(STOP_IDX + 1);

  // ticks per bit for the selected mode
  function automatic logic [1:0] ticks_per_bit(input logic three);
    return three ? 2'd3 : 2'd2;
  endfunction

  // phase after the next tick, wrapping at the ticks-per-bit count
  function automatic logic [1:0] next_phase(input logic [1:0] ph, input logic three);
    return (ph == ticks_per_bit(three) - 2'd1) ? 2'd0 : ph + 2'd1;
  endfunction
endpackage

// File: rtl/gurx_sync.sv
module gurx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic line,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign line = s2;
  assign fall = s3 & ~s2;
endmodule

// File: rtl/gurx_divider.sv
module gurx_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic [DIV_W-1:0] div_in,
  output logic [DIV_W-1:0] div_q,
  output logic [DIV_W-1:0] cnt,
  output logic             tick
);
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  logic wrap;
  assign wrap = (cnt == div_q - DIV_W'(1));
  assign tick = busy & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(1);
      cnt   <= '0;
    end else if (start) begin
      div_q <= eff_div(div_in);
      cnt   <= '0;
    end else if (!busy || wrap) begin
      cnt   <= '0;
    end else begin
      cnt   <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/gurx_frame.sv
module gurx_frame
  import gurx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line,
  input  logic              fall,
  input  logic              mode_in,
  input  logic              tick,
  output logic              busy,
  output logic              start,
  output logic              mode_q,
  output logic              frame_end,
  output logic              abort,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              stab_err,
  output logic              frame_err
);
  logic [1:0]        ph, ph_n;
  logic [BIDX_W-1:0] bitk;
  logic [DATA_W-1:0] shreg;
  logic              ref_lvl, stab_on, stab_flag, viol, sample_now;

  assign ph_n       = next_phase(ph, mode_q);
  assign sample_now = busy & tick & (ph_n == ticks_per_bit(mode_q) - 2'd1);
  assign start      = ~busy & fall;
  assign abort      = sample_now & (bitk == '0) & line;
  assign frame_end  = sample_now & (bitk == BIDX_W'(STOP_IDX));
  // the bit boundary tick itself is excluded: the line may legally move there
  assign viol = busy & mode_q & stab_on & (line != ref_lvl) & ~(tick & (ph_n == 2'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      mode_q    <= 1'b0;
      ph        <= '0;
      bitk      <= '0;
      shreg     <= '0;
      ref_lvl   <= 1'b1;
      stab_on   <= 1'b0;
      stab_flag <= 1'b0;
      rx_byte   <= '0;
      rx_valid  <= 1'b0;
      stab_err  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      stab_err  <= 1'b0;
      frame_err <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        mode_q    <= mode_in;
        ph        <= '0;
        bitk      <= '0;
        stab_on   <= 1'b0;
        stab_flag <= 1'b0;
      end else if (busy) begin
        if (viol) stab_flag <= 1'b1;
        if (tick) begin
          ph <= ph_n;
          if (ph_n == 2'd0) begin
            bitk    <= bitk + BIDX_W'(1);
            stab_on <= 1'b0;
          end
          if (mode_q && ph_n == 2'd1) begin
            ref_lvl <= line;
            stab_on <= 1'b1;
          end
        end
        if (sample_now) begin
          if (bitk == '0) begin
            if (line) busy <= 1'b0;
          end else if (bitk == BIDX_W'(STOP_IDX)) begin
            busy      <= 1'b0;
            rx_byte   <= shreg;
            rx_valid  <= line;
            frame_err <= ~line;
            stab_err  <= stab_flag | viol;
          end else begin
            shreg <= {line, shreg[DATA_W-1:1]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/gated_uart_rx.sv
module gated_uart_rx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             tick3_mode,
  input  logic             rx_line,
  output logic [7:0]       rx_byte,
  output logic             rx_valid,
  output logic             stab_err,
  output logic             frame_err
);
  logic             line_s, line_fall;
  logic             busy, start, tick, mode_q, frame_end, abort;
  logic [DIV_W-1:0] div_q, div_cnt;

  gurx_sync u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .line (line_s),
    .fall (line_fall)
  );

  gurx_divider #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .div_in(divisor),
    .div_q (div_q),
    .cnt   (div_cnt),
    .tick  (tick)
  );

  gurx_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .line     (line_s),
    .fall     (line_fall),
    .mode_in  (tick3_mode),
    .tick     (tick),
    .busy     (busy),
    .start    (start),
    .mode_q   (mode_q),
    .frame_end(frame_end),
    .abort    (abort),
    .rx_byte  (rx_byte),
    .rx_valid (rx_valid),
    .stab_err (stab_err),
    .frame_err(frame_err)
  );
endmodule

// File: rtl/gurx_checker.sv
module gurx_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mode_q,
  input logic             frame_end,
  input logic             abort,
  input logic [DIV_W-1:0] div_q,
  input logic [DIV_W-1:0] div_cnt,
  input logic             rx_valid,
  input logic             stab_err,
  input logic             frame_err
);
  a_r1_div_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> div_cnt == '0);

  a_r2_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_q));

  a_r5_abort_silent: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !rx_valid && !frame_err));

  a_r8_stab_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    stab_err |-> (rx_valid || frame_err));

  a_r8_stab_mode3_only: assert property (@(posedge clk) disable iff (!rst_n)
    stab_err |-> mode_q);

  a_r9_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !busy);

  a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r10_ferr_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && frame_err));
endmodule

bind gated_uart_rx gurx_checker #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .mode_q   (mode_q),
  .frame_end(frame_end),
  .abort    (abort),
  .div_q    (div_q),
  .div_cnt  (div_cnt),
  .rx_valid (rx_valid),
  .stab_err (stab_err),
  .frame_err(frame_err)
);

// File: tb/gated_uart_rx_bench.sv
module gated_uart_rx_bench;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] divisor = 16'd4;
  logic             tick3_mode = 1'b0;
  logic             rx_line = 1'b1;
  logic [7:0]       rx_byte;
  logic             rx_valid, stab_err, frame_err;

  int checks = 0;
  int failures = 0;
  int n_valid = 0, n_ferr = 0, n_serr = 0, n_wide = 0;
  logic [7:0] last_byte = 8'h00;
  logic prev_v = 1'b0, prev_f = 1'b0, prev_s = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gated_uart_rx #(.DIV_W(DIV_W)) u_gated_uart_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .divisor   (divisor),
    .tick3_mode(tick3_mode),
    .rx_line   (rx_line),
    .rx_byte   (rx_byte),
    .rx_valid  (rx_valid),
    .stab_err  (stab_err),
    .frame_err (frame_err)
  );

  // output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin n_valid++; last_byte = rx_byte; end
      if (frame_err) begin n_ferr++; last_byte = rx_byte; end
      if (stab_err) n_serr++;
      if ((rx_valid && prev_v) || (frame_err && prev_f) || (stab_err && prev_s)) n_wide++;
      if (rx_valid && frame_err) n_wide++;
      prev_v = rx_valid; prev_f = frame_err; prev_s = stab_err;
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic clear_counts();
    n_valid = 0; n_ferr = 0; n_serr = 0;
  endtask

  function automatic int bit_time();
    int d = (divisor == 0) ? 1 : int'(divisor);
    return d * (tick3_mode ? 3 : 2);
  endfunction

  task automatic idle(input int n);
    rx_line = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // gbit/goff: bit index and offset of a one-clock inversion (-1 for none)
  // chg: rewrite the divisor to 9 at the start of data bit 1
  task automatic send(input logic [7:0] b, input logic stop_v,
                      input int gbit, input int goff, input bit chg);
    int bt = bit_time();
    for (int k = 0; k < 10; k++) begin
      logic v = (k == 0) ? 1'b0 : (k == 9) ? stop_v : b[k-1];
      for (int c = 0; c < bt; c++) begin
        if (chg && k == 2 && c == 0) divisor = 16'd9;
        rx_line = (k == gbit && c == goff) ? ~v : v;
        @(negedge clk);
      end
    end
    rx_line = 1'b1;
  endtask

  task automatic expect_result(input string tag, input int v, input int f,
                               input int s, input logic [7:0] b);
    check_eq({tag, " valid count"}, n_valid, v);
    check_eq({tag, " frame_err count"}, n_ferr, f);
    check_eq({tag, " stab_err count"}, n_serr, s);
    if (v + f > 0) check_eq({tag, " byte"}, int'(last_byte), int'(b));
  endtask

  task automatic t_reset();
    check_eq("R1 reset rx_valid", int'(rx_valid), 0);
    check_eq("R1 reset frame_err", int'(frame_err), 0);
    check_eq("R1 reset stab_err", int'(stab_err), 0);
    check_eq("R1 reset rx_byte", int'(rx_byte), 0);
  endtask

  task automatic t_mode2_basic();
    tick3_mode = 1'b0; divisor = 16'd4; clear_counts();
    idle(200); // long idle first: divider must be parked at zero (R1)
    send(8'hA5, 1'b1, -1, 0, 1'b0); idle(20);
    expect_result("R3 R7 R1 two-tick 0xA5", 1, 0, 0, 8'hA5);
  endtask

  task automatic t_rate();
    tick3_mode = 1'b0; divisor = 16'd7; clear_counts();
    send(8'h3C, 1'b1, -1, 0, 1'b0); idle(30);
    expect_result("R2 divisor 7 0x3C", 1, 0, 0, 8'h3C);
    divisor = 16'd0; clear_counts();
    send(8'hC3, 1'b1, -1, 0, 1'b0); idle(10);
    expect_result("R2 divisor 0 as 1", 1, 0, 0, 8'hC3);
  endtask

  task automatic t_mode3_basic();
    tick3_mode = 1'b1; divisor = 16'd4; clear_counts();
    send(8'h5A, 1'b1, -1, 0, 1'b0); idle(20);
    expect_result("R4 three-tick 0x5A", 1, 0, 0, 8'h5A);
    clear_counts();
    send(8'hFF, 1'b1, -1, 0, 1'b0); idle(20);
    expect_result("R4 three-tick 0xFF", 1, 0, 0, 8'hFF);
    clear_counts();
    send(8'h00, 1'b1, -1, 0, 1'b0); idle(20);
    expect_result("R4 three-tick 0x00", 1, 0, 0, 8'h00);
  endtask

  task automatic t_stop_low();
    tick3_mode = 1'b0; divisor = 16'd4; clear_counts();
    send(8'h81, 1'b0, -1, 0, 1'b0); idle(20);
    expect_result("R6 stop low", 0, 1, 0, 8'h81);
  endtask

  task automatic t_false_start();
    tick3_mode = 1'b0; divisor = 16'd4; clear_counts();
    rx_line = 1'b0; repeat (2) @(negedge clk);
    idle(40);
    expect_result("R5 false start", 0, 0, 0, 8'h00);
    send(8'h6E, 1'b1, -1, 0, 1'b0); idle(20);
    expect_result("R5 R9 frame after false start", 1, 0, 0, 8'h6E);
  endtask

  task automatic t_stab_glitch();
    tick3_mode = 1'b1; divisor = 16'd4; clear_counts();
    // bit 3 (data bit 2), offset 6: between reference (4) and sample (8)
    send(8'h96, 1'b1, 3, 6, 1'b0); idle(20);
    expect_result("R8 stable-zone glitch", 1, 0, 1, 8'h96);
    clear_counts();
    send(8'h96, 1'b1, -1, 0, 1'b0); idle(20);
    expect_result("R8 flag cleared next frame", 1, 0, 0, 8'h96);
    clear_counts();
    send(8'h96, 1'b0, 9, 5, 1'b0); idle(20);
    expect_result("R8 R6 stop-bit glitch", 0, 1, 1, 8'h96);
  endtask

  task automatic t_transition_glitch();
    tick3_mode = 1'b1; divisor = 16'd4; clear_counts();
    send(8'h96, 1'b1, 3, 1, 1'b0); idle(20);
    expect_result("R8 transition-zone glitch ignored", 1, 0, 0, 8'h96);
    tick3_mode = 1'b0; clear_counts();
    send(8'h96, 1'b1, 3, 6, 1'b0); idle(20);
    expect_result("R8 two-tick mode no stab_err", 1, 0, 0, 8'h96);
  endtask

  task automatic t_div_change();
    tick3_mode = 1'b0; divisor = 16'd4; clear_counts();
    send(8'hD2, 1'b1, -1, 0, 1'b1); idle(20);
    expect_result("R2 divisor change mid-frame ignored", 1, 0, 0, 8'hD2);
    divisor = 16'd4;
  endtask

  task automatic t_back_to_back();
    tick3_mode = 1'b1; divisor = 16'd4; clear_counts();
    send(8'h11, 1'b1, -1, 0, 1'b0);
    send(8'hEE, 1'b1, -1, 0, 1'b0); idle(20);
    expect_result("R9 back-to-back", 2, 0, 0, 8'hEE);
  endtask

  task automatic t_pulse_width();
    check_eq("R10 pulse width and exclusivity", n_wide, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode2_basic();
    t_rate();
    t_mode3_basic();
    t_stop_low();
    t_false_start();
    t_stab_glitch();
    t_transition_glitch();
    t_div_change();
    t_back_to_back();
    t_pulse_width();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule